// File: doc/BRIEF.md
# Converter Start-Up Register Sequencer

This block programs a high-speed data converter after power-up. A fixed list of register writes goes out one frame at a time over a write-only three-wire serial port (clock, active-low select, data). Each frame is 24 bits: a 16-bit register address on top and an 8-bit value in the low byte, sent most significant bit first. The list opens with a soft reset, then holds the port quiet for a counted delay. It then turns the serial link off before calibration, loads the link-mode, K, sync, scrambler, test-pattern and two gain registers, turns calibration on before the link, and ends with a calibration trigger written low and then high.

A second function helps tune the serial lanes. Each pulse on the sweep input, while the block is idle, writes one new value to the pre-emphasis register. The first pulse writes 1, and each further pulse adds one until a programmable ceiling, after which the value returns to 1.

The controller is a five-state machine. The states are ST_IDLE, ST_ISSUE, ST_XFER, ST_HOLD and ST_FINISH. A start pulse or a sweep pulse moves ST_IDLE to ST_ISSUE, and ST_ISSUE always moves on to ST_XFER. When the shifter reports a finished frame, ST_XFER moves to one of four states: ST_IDLE after a sweep write, ST_HOLD after the reset frame, ST_FINISH after the last list entry, and back to ST_ISSUE otherwise. ST_HOLD moves to ST_ISSUE when the wait timer expires. ST_FINISH moves to ST_IDLE.

Top module: `cfg_seq_top`

## Requirements
- R1: Every frame holds select low for exactly 24 serial clock rising edges. Data is valid at each rising edge and is sent MSB first, with address bits [23:8] and the value in bits [7:0]. While select is high the serial clock stays low.
- R2: The first frame of a sequence is address 0x0000 with value 0xB0.
- R3: After the reset frame ends, select stays high for at least WAIT_CYCLES clock cycles before the next frame begins.
- R4: Frames 2 and 3 are 0x0200 <- 0x00 (link off) and then 0x0061 <- 0x00 (calibration off).
- R5: Frames 4 to 10 are, in this order: 0x0201 <- JMODE_VAL, 0x0202 <- K_VAL, 0x0203 <- SYNC_VAL, 0x0204 <- SCRAMBLE_VAL, 0x0205 <- TEST_VAL, 0x0030 <- GAIN_VAL and 0x0032 <- GAIN_VAL.
- R6: Frames 11 and 12 are 0x0061 <- 0x01 (calibration on) and then 0x0200 <- 0x01 (link on).
- R7: Frames 13 and 14 are 0x006C <- 0x00 and then 0x006C <- 0x01. A sequence has exactly 14 frames.
- R8: Busy is high from the cycle after start is sampled until done is sampled. Done is high for exactly one cycle after the last frame, and busy is low in the following cycle.
- R9: A sweep pulse while idle sends exactly one frame to address 0x0048. The values sent are 1, 2, ... up to EMPH_MAX, and then 1 again.
- R10: Start and sweep pulses that arrive while busy are ignored. They add no frames and do not change the next pre-emphasis value.
- R11: In reset, select is high, the serial clock is low, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launches the start-up list when idle |
| sweep_i | input | 1 | Requests one pre-emphasis step when idle |
| busy_o | output | 1 | High while a list or sweep write is in progress |
| done_o | output | 1 | One-cycle pulse when the list completes |
| spi_sclk_o | output | 1 | Serial clock, idles low |
| spi_cs_n_o | output | 1 | Active-low frame select |
| spi_mosi_o | output | 1 | Serial data, MSB first |

## Verification
The hardest conditions to reach from the ports are start and sweep requests that arrive in the middle of a list. Such a request could restart the list or advance the pre-emphasis value without anyone noticing. The stimulus injects these pulses at random offsets during a running sequence. It then checks that the frame count stays at 14 and that the next real sweep still writes 1. A run of random-gap sweeps long enough to cross the ceiling covers the wrap back to 1, and a second full sequence after the sweeps shows that sweep state does not disturb the list.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_XFER,
        ST_HOLD,
        ST_FINISH
    } seq_state_t;

    localparam int unsigned FRAME_W    = 24;
    localparam int unsigned STEP_COUNT = 14;
    localparam int unsigned STEP_W     = 4;
    localparam logic [15:0] EMPH_ADDR  = 16'h0048;

    // Start-up list; the order of link/calibration writes is behaviour.
    function automatic logic [FRAME_W-1:0] step_word(
        input logic [STEP_W-1:0] idx,
        input logic [7:0]        jmode,
        input logic [7:0]        kval,
        input logic [7:0]        sync,
        input logic [7:0]        scram,
        input logic [7:0]        tpat,
        input logic [7:0]        gain
    );
        logic [FRAME_W-1:0] w;
        unique case (idx)
            4'd0:    w = {16'h0000, 8'hB0};
            4'd1:    w = {16'h0200, 8'h00};
            4'd2:    w = {16'h0061, 8'h00};
            4'd3:    w = {16'h0201, jmode};
            4'd4:    w = {16'h0202, kval};
            4'd5:    w = {16'h0203, sync};
            4'd6:    w = {16'h0204, scram};
            4'd7:    w = {16'h0205, tpat};
            4'd8:    w = {16'h0030, gain};
            4'd9:    w = {16'h0032, gain};
            4'd10:   w = {16'h0061, 8'h01};
            4'd11:   w = {16'h0200, 8'h01};
            4'd12:   w = {16'h006C, 8'h00};
            4'd13:   w = {16'h006C, 8'h01};
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/cfg_spi_shifter.sv
module cfg_spi_shifter #(
    parameter int unsigned FRAME_W = 24,
    parameter int unsigned HALF    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] word_i,
    output logic               done_o,
    output logic               sclk_o,
    output logic               cs_n_o,
    output logic               mosi_o
);
    localparam int unsigned DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int unsigned BIT_W = $clog2(FRAME_W);

    logic [FRAME_W-1:0] sh_q;
    logic [DIV_W-1:0]   div_q;
    logic [BIT_W-1:0]   bit_q;
    logic               act_q, sclk_q, cs_q, done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            div_q  <= '0;
            bit_q  <= '0;
            act_q  <= 1'b0;
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!act_q) begin
                if (load_i) begin
                    act_q  <= 1'b1;
                    cs_q   <= 1'b0;
                    sh_q   <= word_i;
                    div_q  <= '0;
                    bit_q  <= '0;
                    sclk_q <= 1'b0;
                end
            end else if (div_q == DIV_W'(HALF - 1)) begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                end else begin
                    sclk_q <= 1'b0;
                    if (bit_q == BIT_W'(FRAME_W - 1)) begin
                        act_q  <= 1'b0;
                        cs_q   <= 1'b1;
                        done_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                        sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign done_o = done_q;
    assign sclk_o = sclk_q;
    assign cs_n_o = cs_q;
    assign mosi_o = sh_q[FRAME_W-1];

endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
    parameter int unsigned CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    output logic expire_o
);
    localparam int unsigned CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (arm_i) begin
            cnt_q <= CNT_W'(CYCLES - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = run_q && (cnt_q == '0);

endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top
    import cfg_seq_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES  = 5000,
    parameter int unsigned SCLK_HALF    = 2,
    parameter int unsigned EMPH_MAX     = 4,
    parameter logic [7:0]  JMODE_VAL    = 8'h01,
    parameter logic [7:0]  K_VAL        = 8'h03,
    parameter logic [7:0]  SYNC_VAL     = 8'h01,
    parameter logic [7:0]  SCRAMBLE_VAL = 8'h00,
    parameter logic [7:0]  TEST_VAL     = 8'h05,
    parameter logic [7:0]  GAIN_VAL     = 8'hFF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic sweep_i,
    output logic busy_o,
    output logic done_o,
    output logic spi_sclk_o,
    output logic spi_cs_n_o,
    output logic spi_mosi_o
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEP_COUNT - 1);
    localparam logic [7:0]        EMPH_TOP  = 8'(EMPH_MAX);

    seq_state_t          state_q, state_d;
    logic [STEP_W-1:0]   step_q;
    logic                sweep_q;
    logic [7:0]          emph_q, emph_next;
    logic                spi_done, spi_load, tmr_arm, tmr_expire;
    logic [FRAME_W-1:0]  word;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i || sweep_i) state_d = ST_ISSUE;
            ST_ISSUE:  state_d = ST_XFER;
            ST_XFER:   if (spi_done) begin
                           if (sweep_q)                 state_d = ST_IDLE;
                           else if (step_q == '0)       state_d = ST_HOLD;
                           else if (step_q == LAST_STEP) state_d = ST_FINISH;
                           else                         state_d = ST_ISSUE;
                       end
            ST_HOLD:   if (tmr_expire) state_d = ST_ISSUE;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign emph_next = (emph_q == '0 || emph_q >= EMPH_TOP) ? 8'h01 : emph_q + 8'h01;

    // step index, mode flag and pre-emphasis value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q  <= '0;
            sweep_q <= 1'b0;
            emph_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        step_q  <= '0;
                        sweep_q <= 1'b0;
                    end else if (sweep_i) begin
                        sweep_q <= 1'b1;
                        emph_q  <= emph_next;
                    end
                end
                ST_XFER: begin
                    if (spi_done && !sweep_q && step_q != '0 && step_q != LAST_STEP)
                        step_q <= step_q + 1'b1;
                end
                ST_HOLD: begin
                    if (tmr_expire) step_q <= STEP_W'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        spi_load = (state_q == ST_ISSUE);
        tmr_arm  = (state_q == ST_XFER) && spi_done && !sweep_q && (step_q == '0);
        busy_o   = (state_q != ST_IDLE);
        done_o   = (state_q == ST_FINISH);
        word     = sweep_q ? {EMPH_ADDR, emph_q}
                           : step_word(step_q, JMODE_VAL, K_VAL, SYNC_VAL,
                                       SCRAMBLE_VAL, TEST_VAL, GAIN_VAL);
    end

    cfg_spi_shifter #(
        .FRAME_W (FRAME_W),
        .HALF    (SCLK_HALF)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (spi_load),
        .word_i (word),
        .done_o (spi_done),
        .sclk_o (spi_sclk_o),
        .cs_n_o (spi_cs_n_o),
        .mosi_o (spi_mosi_o)
    );

    cfg_wait_timer #(
        .CYCLES (WAIT_CYCLES)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (tmr_arm),
        .expire_o (tmr_expire)
    );

endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk
    import cfg_seq_pkg::*;
#(
    parameter int unsigned EMPH_MAX = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       sclk,
    input logic       cs_n,
    input logic       mosi,
    input seq_state_t state,
    input logic [7:0] emph
);
    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n);            // R11
    AST_SCLK_PARKED:   assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);            // R1
    AST_MOSI_HELD:     assert property (@(posedge clk) disable iff (!rst_n) (sclk && $past(sclk)) |-> $stable(mosi)); // R1
    AST_HOLD_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) (state == ST_HOLD) |-> cs_n); // R3
    AST_DONE_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);            // R8
    AST_DONE_BUSY:     assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);            // R8
    AST_EMPH_RANGE:    assert property (@(posedge clk) disable iff (!rst_n) (emph != 8'h00) |-> (emph <= 8'(EMPH_MAX))); // R9
endmodule

bind cfg_seq_top cfg_seq_chk #(.EMPH_MAX(EMPH_MAX)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy_o),
    .done  (done_o),
    .sclk  (spi_sclk_o),
    .cs_n  (spi_cs_n_o),
    .mosi  (spi_mosi_o),
    .state (state_q),
    .emph  (emph_q)
);

// File: tb/cfg_seq_top_tb.sv
`timescale 1ns/1ps
module cfg_seq_top_tb;
    localparam int unsigned WAIT_CYCLES = 5000;
    localparam int unsigned EMPH_MAX    = 4;
    localparam logic [7:0]  JM = 8'h01, KV = 8'h03, SY = 8'h01, SC = 8'h00, TP = 8'h05, GN = 8'hFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic sweep = 1'b0;
    logic busy, done, sclk, cs_n, mosi;

    always #4 clk = ~clk;

    cfg_seq_top #(
        .WAIT_CYCLES(WAIT_CYCLES), .SCLK_HALF(2), .EMPH_MAX(EMPH_MAX),
        .JMODE_VAL(JM), .K_VAL(KV), .SYNC_VAL(SY), .SCRAMBLE_VAL(SC),
        .TEST_VAL(TP), .GAIN_VAL(GN)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sweep_i(sweep),
        .busy_o(busy), .done_o(done), .spi_sclk_o(sclk),
        .spi_cs_n_o(cs_n), .spi_mosi_o(mosi)
    );

    int n_chk = 0;
    int n_fail = 0;
    longint cyc = 0;
    longint t_rise0 = 0;
    longint t_fall1 = 0;
    logic [23:0] mon_sh = '0;
    int mon_bits = 0;
    int nfr = 0;
    logic [23:0] frames [0:63];
    logic [7:0] exp_emph = 8'h00;

    always @(posedge clk) cyc++;

    always @(posedge sclk) if (!cs_n) begin
        mon_sh = {mon_sh[22:0], mosi};
        mon_bits++;
    end

    always @(negedge cs_n) if (rst_n) begin
        mon_bits = 0;
        if (nfr == 1) t_fall1 = cyc;
    end

    always @(posedge cs_n) if (rst_n && mon_bits != 0) begin
        n_chk++;
        if (mon_bits != 24) begin
            n_fail++;
            $display("FAIL R1 frame bit count act=%0d exp=24", mon_bits);
        end
        if (nfr < 64) frames[nfr] = mon_sh;
        if (nfr == 0) t_rise0 = cyc;
        nfr++;
        mon_bits = 0;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_frame(input int i);
        case (i)
            0:  return {16'h0000, 8'hB0};
            1:  return {16'h0200, 8'h00};
            2:  return {16'h0061, 8'h00};
            3:  return {16'h0201, JM};
            4:  return {16'h0202, KV};
            5:  return {16'h0203, SY};
            6:  return {16'h0204, SC};
            7:  return {16'h0205, TP};
            8:  return {16'h0030, GN};
            9:  return {16'h0032, GN};
            10: return {16'h0061, 8'h01};
            11: return {16'h0200, 8'h01};
            12: return {16'h006C, 8'h00};
            default: return {16'h006C, 8'h01};
        endcase
    endfunction

    function automatic string frame_tag(input int i);
        if (i == 0) return "R2 reset frame";
        if (i <= 2) return "R4 shutdown order";
        if (i <= 9) return "R5 config frames";
        if (i <= 11) return "R6 bring-up order";
        return "R7 trigger frames";
    endfunction

    task automatic run_seq(input bit poke);
        int base;
        base = nfr;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R8 busy after start", 32'(busy), 32'd1);
        if (poke) begin
            for (int k = 0; k < 5; k++) begin
                repeat ($urandom_range(50, 800)) @(negedge clk);
                if ($urandom_range(0, 1) == 1) start = 1'b1;
                else sweep = 1'b1;
                @(negedge clk);
                start = 1'b0;
                sweep = 1'b0;
            end
        end
        while (!done) begin
            @(negedge clk);
            if (!done && !busy) begin
                chk(1'b0, "R8 busy dropped early", 32'(busy), 32'd1);
                break;
            end
        end
        chk(nfr - base == 14, poke ? "R10 R7 frame count with stray pulses" : "R7 frame count",
            32'(nfr - base), 32'd14);
        @(negedge clk);
        chk(!done, "R8 done single cycle", 32'(done), 32'd0);
        chk(!busy, "R8 busy low after done", 32'(busy), 32'd0);
        for (int i = 0; i < 14; i++)
            chk(frames[base + i] == exp_frame(i), frame_tag(i), 32'(frames[base + i]), 32'(exp_frame(i)));
    endtask

    task automatic do_sweep();
        int base;
        base = nfr;
        @(negedge clk) sweep = 1'b1;
        @(negedge clk) sweep = 1'b0;
        while (busy) @(negedge clk);
        exp_emph = (exp_emph == 8'h00 || exp_emph >= 8'(EMPH_MAX)) ? 8'h01 : exp_emph + 8'h01;
        chk(nfr - base == 1, "R9 one frame per sweep", 32'(nfr - base), 32'd1);
        chk(frames[nfr - 1] == {16'h0048, exp_emph}, "R9 sweep value",
            32'(frames[nfr - 1]), 32'({16'h0048, exp_emph}));
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R11 serial idle in reset", {30'd0, cs_n, sclk}, 32'h2);
        chk(busy == 1'b0 && done == 1'b0, "R11 flags low in reset", {30'd0, busy, done}, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run_seq(1'b0);
        chk((t_fall1 - t_rise0) >= longint'(WAIT_CYCLES) && (t_fall1 - t_rise0) <= longint'(WAIT_CYCLES + 8),
            "R3 post-reset quiet gap", 32'(t_fall1 - t_rise0), 32'(WAIT_CYCLES));

        run_seq(1'b1);
        do_sweep();

        for (int s = 0; s < 10; s++) begin
            repeat ($urandom_range(0, 30)) @(negedge clk);
            do_sweep();
        end

        run_seq(1'b0);
        do_sweep();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule